// File: doc/BRIEF.md
# Bit Matrix Multiply Unit

This execution unit keeps a square bit matrix, WIDTH by WIDTH (64 by 64 by default), as architectural state. It multiplies a WIDTH-bit operand by that matrix over GF(2), so one operation can apply any fixed linear bit mapping to a word. Examples are an arbitrary bit permutation, a bit reversal, or one row step of a tile transpose. The same operation port also offers two counting operations on a single word: leading zeros and set bits. A vector form is obtained by issuing one scalar operation per element, one element per cycle.

The matrix is filled through a separate row port, one row per cycle. Each row write carries the index of the row it fills. A fill is a run of WIDTH row writes, and the rows may arrive in any order. While a fill is under way the unit lowers `op_ready`, and multiplies are held off. The two counting operations do not use the matrix, so they are accepted at any time. Every accepted operation returns its result exactly two cycles after issue, and a new operation can be issued on every cycle.

Top module: `bmm_unit`

## Requirements
- R1: After reset, `res_valid` is 0, `op_ready` is 1, and every matrix element is 0, so a multiply issued before any fill returns 0.
- R2: A row write with `ld_valid` high stores `ld_row` as row `ld_idx`. Matrix element (i, j) is bit j of row i.
- R3: `op_ready` is low in any cycle in which `ld_valid` is high. It also stays low from the first row write of a fill until that fill's WIDTH-th row write has been taken. It is high again in the next cycle that has no row write.
- R4: A multiply presented while `op_ready` is low is dropped and produces no result.
- R5: Leading-zero and population-count operations are accepted whenever `op_valid` is high, whatever the state of `op_ready`.
- R6: Opcode 2'b00 (multiply) returns a word whose bit j is the XOR over all i of operand bit i AND element (i, j). This is the parity of the operand ANDed with column j.
- R7: Opcode 2'b01 returns the number of zero bits above the highest set bit, counted down from bit WIDTH-1, in the low bits of the result. An all-zero operand returns WIDTH.
- R8: Opcode 2'b10 returns the number of set bits in the operand, a value from 0 to WIDTH.
- R9: Opcode 2'b11 is reserved. It is accepted and returns 0.
- R10: An operation accepted at a clock edge has `res_valid` high with its result in the cycle after the following edge. Operations issued on consecutive cycles return on consecutive cycles, in issue order.
- R11: A multiply already accepted is computed from the matrix as it was when the multiply was accepted. A row write that starts in the cycle after the multiply is accepted does not change that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Row write strobe |
| ld_idx | input | $clog2(WIDTH) | Index of the row being written |
| ld_row | input | WIDTH | Row contents; bit j is column j |
| op_valid | input | 1 | Operation present |
| op_code | input | 2 | 00 multiply, 01 leading zeros, 10 population count, 11 reserved |
| op_arg | input | WIDTH | Operand word |
| op_ready | output | 1 | Low while a fill is under way; multiplies are only taken when high |
| res_valid | output | 1 | Result present |
| res_data | output | WIDTH | Result word; counts are zero-extended |

## Verification
The bench runs the unit at an 8-bit width, where each operation can be swept over every operand. A bit-order slip in the product, such as using rows for columns, shows up under a non-symmetric matrix even though an identity matrix would hide it. The same goes for a leading-zero count that returns WIDTH-1 or wraps to 0 on a zero word, and for a population count that stops short at the all-ones word. The fills write rows in reverse index order while multiplies and counts are offered in the same cycles. A unit that took a multiply during a fill would emit an unexpected result, and one that stalled the counts would lose an expected result. A further multiply is issued just before a new fill starts, which catches a product computed from a matrix that was updated too early.

// File: rtl/bmm_pkg.sv
package bmm_pkg;

  typedef enum logic [1:0] {
    BMM_OP_MUL  = 2'b00,
    BMM_OP_LZC  = 2'b01,
    BMM_OP_POPC = 2'b10,
    BMM_OP_RSVD = 2'b11
  } bmm_op_e;

endpackage

// File: rtl/bmm_matrix_store.sv
module bmm_matrix_store #(
  parameter int W = 64,
  localparam int IW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_valid,
  input  logic [IW-1:0]  ld_idx,
  input  logic [W-1:0]   ld_row,
  output logic [W*W-1:0] mat_flat,
  output logic           load_busy
);

  logic [W-1:0]  rows_q [W];
  logic [IW-1:0] fill_cnt_q;
  logic          fill_last;

  // a fill is W writes; the counter returns to zero after the last one
  assign fill_last = (fill_cnt_q == IW'(W - 1));
  assign load_busy = ld_valid || (fill_cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt_q <= '0;
    end else if (ld_valid) begin
      fill_cnt_q <= fill_last ? '0 : fill_cnt_q + 1'b1;
    end
  end

  for (genvar r = 0; r < W; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rows_q[r] <= '0;
      end else if (ld_valid && (ld_idx == IW'(r))) begin
        rows_q[r] <= ld_row;
      end
    end
    assign mat_flat[r*W +: W] = rows_q[r];
  end

endmodule

// File: rtl/bmm_exec.sv
module bmm_exec #(
  parameter int W = 64,
  localparam int CW = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  bmm_pkg::bmm_op_e op_code,
  input  logic [W-1:0]     op_arg,
  input  logic             load_busy,
  input  logic [W*W-1:0]   mat_flat,
  output logic             op_accept,
  output logic             mul_accept,
  output logic             s1_valid,
  output logic             res_valid,
  output bmm_pkg::bmm_op_e res_code,
  output logic [W-1:0]     res_data
);
  import bmm_pkg::*;

  // GF(2) vector-matrix product: XOR of the rows selected by operand bits
  function automatic logic [W-1:0] gf2_product(logic [W-1:0] a, logic [W*W-1:0] m);
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++) begin
      if (a[i]) acc = acc ^ m[i*W +: W];
    end
    return acc;
  endfunction

  function automatic logic [CW-1:0] lead_zeros(logic [W-1:0] a);
    logic [CW-1:0] n;
    n = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (a[i]) n = CW'(W - 1 - i);
    end
    return n;
  endfunction

  function automatic logic [CW-1:0] ones_count(logic [W-1:0] a);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) begin
      n = n + CW'(a[i]);
    end
    return n;
  endfunction

  bmm_op_e      s1_code_q;
  logic [W-1:0] s1_arg_q;
  logic         s1_valid_q;
  logic [W-1:0] s2_value;

  assign mul_accept = op_valid && (op_code == BMM_OP_MUL) && !load_busy;
  assign op_accept  = mul_accept || (op_valid && (op_code != BMM_OP_MUL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_code_q  <= BMM_OP_RSVD;
      s1_arg_q   <= '0;
    end else begin
      s1_valid_q <= op_accept;
      if (op_accept) begin
        s1_code_q <= op_code;
        s1_arg_q  <= op_arg;
      end
    end
  end

  always_comb begin
    unique case (s1_code_q)
      BMM_OP_MUL:  s2_value = gf2_product(s1_arg_q, mat_flat);
      BMM_OP_LZC:  s2_value = W'(lead_zeros(s1_arg_q));
      BMM_OP_POPC: s2_value = W'(ones_count(s1_arg_q));
      default:     s2_value = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_code  <= BMM_OP_RSVD;
      res_data  <= '0;
    end else begin
      res_valid <= s1_valid_q;
      if (s1_valid_q) begin
        res_code <= s1_code_q;
        res_data <= s2_value;
      end
    end
  end

  assign s1_valid = s1_valid_q;

endmodule

// File: rtl/bmm_unit.sv
module bmm_unit #(
  parameter int W = 64,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [IW-1:0] ld_idx,
  input  logic [W-1:0]  ld_row,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [W-1:0]  op_arg,
  output logic          op_ready,
  output logic          res_valid,
  output logic [W-1:0]  res_data
);
  import bmm_pkg::*;

  logic [W*W-1:0] mat_flat;
  logic           load_busy;
  logic           op_accept;
  logic           mul_accept;
  logic           s1_valid;
  bmm_op_e        res_code;

  bmm_matrix_store #(.W(W)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_idx    (ld_idx),
    .ld_row    (ld_row),
    .mat_flat  (mat_flat),
    .load_busy (load_busy)
  );

  bmm_exec #(.W(W)) exec_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (bmm_op_e'(op_code)),
    .op_arg     (op_arg),
    .load_busy  (load_busy),
    .mat_flat   (mat_flat),
    .op_accept  (op_accept),
    .mul_accept (mul_accept),
    .s1_valid   (s1_valid),
    .res_valid  (res_valid),
    .res_code   (res_code),
    .res_data   (res_data)
  );

  assign op_ready = !load_busy;

endmodule

// File: rtl/bmm_unit_chk.sv
module bmm_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ld_valid,
  input logic         op_ready,
  input logic         op_valid,
  input logic [1:0]   op_code,
  input logic         load_busy,
  input logic         op_accept,
  input logic         mul_accept,
  input logic         s1_valid,
  input logic         res_valid,
  input logic [1:0]   res_code,
  input logic [W-1:0] res_data
);

  p_ready_low_on_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !op_ready);

  p_no_mul_in_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mul_accept |-> op_ready);

  p_counts_never_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != 2'b00) |-> op_accept);

  p_lzc_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'b01) |-> (res_data <= W));

  p_popc_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'b10) |-> (res_data <= W));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'b11) |-> (res_data == '0));

  p_accept_to_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |=> s1_valid);

  p_stage_to_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> res_valid);

  p_no_spurious_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !res_valid);

  p_busy_matches_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy |-> !op_ready);

endmodule

bind bmm_unit bmm_unit_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ld_valid   (ld_valid),
  .op_ready   (op_ready),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .load_busy  (load_busy),
  .op_accept  (op_accept),
  .mul_accept (mul_accept),
  .s1_valid   (s1_valid),
  .res_valid  (res_valid),
  .res_code   (res_code),
  .res_data   (res_data)
);

// File: tb/bmm_unit_tb_top.sv
module bmm_unit_tb_top;

  localparam int W = 8;
  localparam int IW = $clog2(W);
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [W-1:0]  ld_row = '0;
  logic          op_valid = 1'b0;
  logic [1:0]    op_code = 2'b00;
  logic [W-1:0]  op_arg = '0;
  logic          op_ready;
  logic          res_valid;
  logic [W-1:0]  res_data;

  bmm_unit #(.W(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_idx    (ld_idx),
    .ld_row    (ld_row),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_arg    (op_arg),
    .op_ready  (op_ready),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [W-1:0] mdl [W];
  int           fill_m = 0;

  logic [W-1:0] exp_q [$];
  string        tag_q [$];
  int           when_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // column-parity form of the product
  function automatic logic [W-1:0] ref_mul(logic [W-1:0] a);
    logic [W-1:0] r;
    logic [W-1:0] col;
    for (int j = 0; j < W; j++) begin
      for (int i = 0; i < W; i++) col[i] = mdl[i][j];
      r[j] = ^(a & col);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_lzc(logic [W-1:0] a);
    int n = 0;
    while (n < W && !a[W-1-n]) n++;
    return W'(n);
  endfunction

  function automatic logic [W-1:0] ref_pop(logic [W-1:0] a);
    logic [W-1:0] x = a;
    int n = 0;
    while (x != '0) begin
      x = x & (x - 1'b1);
      n++;
    end
    return W'(n);
  endfunction

  // result monitor: order, data and two-cycle latency (R10)
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected result", res_data, '0);
      end else begin
        check(res_data == exp_q[0], tag_q[0], res_data, exp_q[0]);
        check(cyc == when_q[0] + 2, "R10 latency", W'(cyc), W'(when_q[0] + 2));
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
        void'(when_q.pop_front());
      end
    end
  end

  // one cycle of stimulus; the model decides acceptance and expectations
  task automatic step(bit ldv, int idx, logic [W-1:0] row,
                      bit opv, logic [1:0] code, logic [W-1:0] arg, string tag);
    bit busy;
    bit take;
    logic [W-1:0] e;
    @(negedge clk);
    ld_valid = ldv;
    ld_idx   = IW'(idx);
    ld_row   = row;
    op_valid = opv;
    op_code  = code;
    op_arg   = arg;
    #1;
    busy = ldv || (fill_m != 0);
    check(op_ready == !busy, "R3 op_ready", W'(op_ready), W'(!busy));
    take = opv && (code != 2'b00 || !busy);
    if (take) begin
      case (code)
        2'b00:   e = ref_mul(arg);
        2'b01:   e = ref_lzc(arg);
        2'b10:   e = ref_pop(arg);
        default: e = '0;
      endcase
      exp_q.push_back(e);
      tag_q.push_back(tag);
      when_q.push_back(cyc);
    end
    if (ldv) begin
      mdl[idx] = row;
      fill_m = (fill_m == W - 1) ? 0 : fill_m + 1;
    end
  endtask

  function automatic logic [W-1:0] pattern_row(int kind, int i);
    case (kind)
      0:       return W'(1) << i;                 // identity
      1:       return W'(1) << (W - 1 - i);       // bit reversal
      default: return W'(i * 73 + 29) ^ W'(i << 3); // irregular
    endcase
  endfunction

  // fill in reverse row order; offer a multiply (must drop, R4) and a
  // leading-zero count (must be taken, R5) while the fill is running
  task automatic fill(int kind);
    for (int k = 0; k < W; k++) begin
      int r = W - 1 - k;
      if (k % 2 == 0)
        step(1'b1, r, pattern_row(kind, r), 1'b1, 2'b00, W'(k + 1), "R4 mul during fill");
      else
        step(1'b1, r, pattern_row(kind, r), 1'b1, 2'b01, W'(k), "R5 lzc during fill");
    end
  endtask

  task automatic mul_sweep(string tag);
    for (int a = 0; a < (1 << W); a++) step(1'b0, 0, '0, 1'b1, 2'b00, W'(a), tag);
  endtask

  initial begin
    for (int i = 0; i < W; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle outputs after reset
    check(res_valid == 1'b0, "R1 res_valid", W'(res_valid), '0);
    check(op_ready == 1'b1, "R1 op_ready", W'(op_ready), W'(1));
    // R1: empty matrix gives a zero product
    step(1'b0, 0, '0, 1'b1, 2'b00, '1, "R1 mul before fill");
    step(1'b0, 0, '0, 1'b1, 2'b00, W'(8'h5a), "R1 mul before fill");

    // R7, R8: every operand, back to back (R10)
    for (int a = 0; a < (1 << W); a++) step(1'b0, 0, '0, 1'b1, 2'b01, W'(a), "R7 lzc");
    for (int a = 0; a < (1 << W); a++) step(1'b0, 0, '0, 1'b1, 2'b10, W'(a), "R8 popc");
    // R9: reserved opcode
    step(1'b0, 0, '0, 1'b1, 2'b11, '1, "R9 reserved");
    step(1'b0, 0, '0, 1'b1, 2'b11, W'(8'h3c), "R9 reserved");

    // R2, R3, R6: identity, then reversal, then irregular matrix
    fill(0);
    step(1'b0, 0, '0, 1'b0, 2'b00, '0, "R3 idle after fill");
    mul_sweep("R6 identity product");
    fill(1);
    mul_sweep("R2 R6 reversal product");
    fill(2);
    mul_sweep("R2 R6 irregular product");

    // R11: multiply taken, then a fill begins on the next cycle
    step(1'b0, 0, '0, 1'b1, 2'b00, W'(8'ha5), "R11 product before new fill");
    fill(1);
    step(1'b0, 0, '0, 1'b1, 2'b00, W'(8'ha5), "R11 product after new fill");

    step(1'b0, 0, '0, 1'b0, 2'b00, '0, "idle");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 missing results", W'(exp_q.size()), '0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule